// File: doc/BRIEF.md
# ISA Legacy Command and Chip-Select Decoder

This block turns an internal bus-cycle descriptor into the command strobes and legacy chip selects seen on an ISA expansion bus. Each clock, the descriptor gives a cycle type (memory, I/O, refresh or idle), a read/write direction, a 24-bit address and a valid flag. From these the block derives five sets of outputs:

- the strobes for the first megabyte of memory;
- the I/O read and write strobes, with an output enable;
- a shared chip select that means ROM on memory cycles and real-time clock on I/O cycles;
- three dedicated strobes for the clock's index and data ports;
- a 16-bit width indication taken from the card's memory-select input.

Every output is registered on the bus clock and active low, apart from the enables and the width flag. An address that is still settling therefore never produces a glitch. When an add-on card has taken ownership of the bus, the block stops driving the I/O strobes and drops their output enable so the pads can act as inputs. The 16-bit I/O select is never driven. Cycles aimed at internal registers stay 8-bit I/O cycles.

Top module: `isa_cmd_decode`

## Requirements
- R1: `smemRdN` goes low one clock after a valid memory read whose address is below 0x100000, or one clock after any valid refresh cycle. Otherwise it is high.
- R2: `smemWrN` goes low one clock after a valid memory write whose address is below 0x100000. Refresh never asserts it.
- R3: `rtcIdxWrN` goes low one clock after a valid I/O write whose low 16 address bits are 0x0070.
- R4: `rtcDatWrN` goes low one clock after a valid I/O write to port 0x0071. `rtcDatRdN` goes low one clock after a valid I/O read from port 0x0071.
- R5: `romRtcSelN` goes low one clock after either of two cycles. The first is a valid memory cycle to 0x0E0000–0x0FFFFF or to 0xFE0000–0xFFFFFF. The second is a valid I/O cycle to port 0x0070 or 0x0071.
- R6: `ioRdN` and `ioWrN` go low one clock after a valid I/O read or write respectively, and `ioCmdOe` is 1. When `extMaster` was 1 in the previous clock, `ioCmdOe` is 0 and both strobes are high.
- R7: `wide16` is 1 one clock after a valid memory cycle that had `memSel16N` low. It is 0 after I/O, refresh and idle cycles, whatever `memSel16N` does.
- R8: `ioSel16Oe` is always 0, so I/O cycles, including those of an external master, stay 8-bit.
- R9: While `rstN` is low, all active-low outputs are high and `ioCmdOe` and `wide16` are 0. Cycle-type encoding: 0 memory, 1 I/O, 2 refresh, 3 idle. `cycValid` low behaves as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycValid | input | 1 | Descriptor valid |
| cycType | input | 2 | 0 memory, 1 I/O, 2 refresh, 3 idle |
| cycWrite | input | 1 | 1 write, 0 read |
| cycAddr | input | 24 | Cycle address |
| extMaster | input | 1 | Add-on card owns the bus |
| memSel16N | input | 1 | 16-bit memory select from the card, active low |
| smemRdN | output | 1 | Low-megabyte memory read strobe |
| smemWrN | output | 1 | Low-megabyte memory write strobe |
| ioRdN | output | 1 | I/O read strobe |
| ioWrN | output | 1 | I/O write strobe |
| ioCmdOe | output | 1 | Output enable for the I/O strobes |
| romRtcSelN | output | 1 | Shared ROM / real-time clock select |
| rtcIdxWrN | output | 1 | Clock index-port write strobe |
| rtcDatWrN | output | 1 | Clock data-port write strobe |
| rtcDatRdN | output | 1 | Clock data-port read strobe |
| wide16 | output | 1 | Current memory cycle is 16-bit |
| ioSel16Oe | output | 1 | Output enable of the 16-bit I/O select, tied off |

## Verification
Addresses are placed on both sides of each boundary: 0x0FFFFF against 0x100000, 0x0DFFFF against 0x0E0000, and 0xFDFFFF against 0xFE0000. These separate the 1 MB qualification from the ROM windows. Ports 0x70, 0x71, 0x72 and 0x1070 show whether the port decode uses the full 16 bits and keeps index and data apart. Refresh cycles with either direction show that refresh counts for reads only. Toggling the memory select during I/O and refresh shows that it is ignored there. Cycles run with the master flag set separate the strobe release from the chip-select decode, which keeps working. A long run of random descriptors then covers the mixed cases.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  typedef enum logic [1:0] {
    CYC_MEM  = 2'd0,
    CYC_IO   = 2'd1,
    CYC_REF  = 2'd2,
    CYC_IDLE = 2'd3
  } cyc_e;

  // Active-high strobe bundle from control to datapath
  typedef struct packed {
    logic smemRd;
    logic smemWr;
    logic ioRd;
    logic ioWr;
    logic romRtcSel;
    logic rtcIdxWr;
    logic rtcDatWr;
    logic rtcDatRd;
    logic memCyc;
  } strobe_t;
endpackage

// File: rtl/isa_dec_ctrl.sv
module isa_dec_ctrl
  import isa_dec_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int LOW_BITS = 20,
  parameter int ROM_BITS = 17,
  parameter int PORT_W   = 16,
  parameter logic [PORT_W-1:0] RTC_IDX_PORT = 16'h0070
) (
  input  logic              cycValid,
  input  logic [1:0]        cycType,
  input  logic              cycWrite,
  input  logic [ADDR_W-1:0] cycAddr,
  output strobe_t           stb
);
  localparam int HI_W   = ADDR_W - LOW_BITS;
  localparam int TOP_W  = ADDR_W - ROM_BITS;
  localparam int WIN_W  = LOW_BITS - ROM_BITS;
  localparam logic [PORT_W-1:0] RTC_DAT_PORT = RTC_IDX_PORT + 1'b1;

  logic isMem, isIo, isRef, lowMeg, romHit, idxHit, datHit;

  always_comb begin
    isMem  = cycValid && (cyc_e'(cycType) == CYC_MEM);
    isIo   = cycValid && (cyc_e'(cycType) == CYC_IO);
    isRef  = cycValid && (cyc_e'(cycType) == CYC_REF);
    lowMeg = (cycAddr[ADDR_W-1:LOW_BITS] == {HI_W{1'b0}});
    romHit = (cycAddr[ADDR_W-1:ROM_BITS] == {TOP_W{1'b1}}) ||
             (lowMeg && (cycAddr[LOW_BITS-1:ROM_BITS] == {WIN_W{1'b1}}));
    idxHit = (cycAddr[PORT_W-1:0] == RTC_IDX_PORT);
    datHit = (cycAddr[PORT_W-1:0] == RTC_DAT_PORT);

    stb.smemRd    = (isMem && !cycWrite && lowMeg) || isRef;
    stb.smemWr    = isMem && cycWrite && lowMeg;
    stb.ioRd      = isIo && !cycWrite;
    stb.ioWr      = isIo && cycWrite;
    stb.romRtcSel = (isMem && romHit) || (isIo && (idxHit || datHit));
    stb.rtcIdxWr  = isIo && cycWrite && idxHit;
    stb.rtcDatWr  = isIo && cycWrite && datHit;
    stb.rtcDatRd  = isIo && !cycWrite && datHit;
    stb.memCyc    = isMem;
  end
endmodule

// File: rtl/isa_dec_dpath.sv
module isa_dec_dpath
  import isa_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    extMaster,
  input  logic    memSel16N,
  output logic    smemRdN,
  output logic    smemWrN,
  output logic    ioRdN,
  output logic    ioWrN,
  output logic    ioCmdOe,
  output logic    romRtcSelN,
  output logic    rtcIdxWrN,
  output logic    rtcDatWrN,
  output logic    rtcDatRdN,
  output logic    wide16
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smemRdN    <= 1'b1;
      smemWrN    <= 1'b1;
      ioRdN      <= 1'b1;
      ioWrN      <= 1'b1;
      ioCmdOe    <= 1'b0;
      romRtcSelN <= 1'b1;
      rtcIdxWrN  <= 1'b1;
      rtcDatWrN  <= 1'b1;
      rtcDatRdN  <= 1'b1;
      wide16     <= 1'b0;
    end else begin
      smemRdN    <= !stb.smemRd;
      smemWrN    <= !stb.smemWr;
      ioRdN      <= !(stb.ioRd && !extMaster);
      ioWrN      <= !(stb.ioWr && !extMaster);
      ioCmdOe    <= !extMaster;
      romRtcSelN <= !stb.romRtcSel;
      rtcIdxWrN  <= !stb.rtcIdxWr;
      rtcDatWrN  <= !stb.rtcDatWr;
      rtcDatRdN  <= !stb.rtcDatRd;
      wide16     <= stb.memCyc && !memSel16N;
    end
  end

  // R6: a released strobe is never asserted
  a_r6_released_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ioCmdOe |-> (ioRdN && ioWrN));
  // R3 / R4: only one clock-port strobe at a time
  a_r4_rtc_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!rtcIdxWrN, !rtcDatWrN, !rtcDatRdN}));
  // R2: a low-memory write never coincides with a read strobe
  a_r2_no_rd_wr: assert property (@(posedge clk) disable iff (!rstN)
    !(!smemRdN && !smemWrN));
endmodule

// File: rtl/isa_cmd_decode.sv
module isa_cmd_decode
  import isa_dec_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycValid,
  input  logic [1:0]        cycType,
  input  logic              cycWrite,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic              extMaster,
  input  logic              memSel16N,
  output logic              smemRdN,
  output logic              smemWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              ioCmdOe,
  output logic              romRtcSelN,
  output logic              rtcIdxWrN,
  output logic              rtcDatWrN,
  output logic              rtcDatRdN,
  output logic              wide16,
  output logic              ioSel16Oe
);
  strobe_t stb;

  isa_dec_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .cycValid(cycValid), .cycType(cycType), .cycWrite(cycWrite),
    .cycAddr(cycAddr), .stb(stb)
  );

  isa_dec_dpath uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .extMaster(extMaster),
    .memSel16N(memSel16N), .smemRdN(smemRdN), .smemWrN(smemWrN),
    .ioRdN(ioRdN), .ioWrN(ioWrN), .ioCmdOe(ioCmdOe),
    .romRtcSelN(romRtcSelN), .rtcIdxWrN(rtcIdxWrN),
    .rtcDatWrN(rtcDatWrN), .rtcDatRdN(rtcDatRdN), .wide16(wide16)
  );

  // R8: 16-bit I/O select is never driven
  assign ioSel16Oe = 1'b0;

  // R1: low-memory read strobe needs low address or refresh
  a_r1_smemrd_qual: assert property (@(posedge clk) disable iff (!rstN)
    !smemRdN |-> $past(cycValid && (cycType == 2'd2 ||
                 (cycType == 2'd0 && cycAddr[ADDR_W-1:20] == '0))));
  // R2: low-memory write strobe needs low address, never refresh
  a_r2_smemwr_qual: assert property (@(posedge clk) disable iff (!rstN)
    !smemWrN |-> $past(cycValid && cycType == 2'd0 && cycWrite &&
                 cycAddr[ADDR_W-1:20] == '0));
  // R6: bus handed to a master releases the I/O strobes
  a_r6_master_release: assert property (@(posedge clk) disable iff (!rstN)
    $past(extMaster) |-> (!ioCmdOe && ioRdN && ioWrN));
  // R7: width select ignored outside memory cycles
  a_r7_sel16_ignored: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cycValid || cycType != 2'd0) |-> !wide16);
endmodule

// File: tb/sim_isa_cmd_decode.sv
module sim_isa_cmd_decode;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycValid = 1'b0;
  logic [1:0] cycType = 2'd3;
  logic cycWrite = 1'b0;
  logic [23:0] cycAddr = '0;
  logic extMaster = 1'b0;
  logic memSel16N = 1'b1;
  logic smemRdN, smemWrN, ioRdN, ioWrN, ioCmdOe, romRtcSelN;
  logic rtcIdxWrN, rtcDatWrN, rtcDatRdN, wide16, ioSel16Oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  isa_cmd_decode u0 (.*);

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b (type=%0d wr=%b addr=%h mst=%b)",
               req, name, act, exp, cycType, cycWrite, cycAddr, extMaster);
    end
  endtask

  // Behavioural model of all outputs for one held descriptor
  task automatic checkAll();
    bit v, mem, io, rf, low, rom, p70, p71;
    v   = cycValid;
    mem = v && cycType == 0;
    io  = v && cycType == 1;
    rf  = v && cycType == 2;
    low = cycAddr < 24'h100000;
    rom = (cycAddr >= 24'h0E0000 && cycAddr <= 24'h0FFFFF) || cycAddr >= 24'hFE0000;
    p70 = cycAddr[15:0] == 16'h0070;
    p71 = cycAddr[15:0] == 16'h0071;
    chk("R1", "smemRdN", smemRdN, !((mem && !cycWrite && low) || rf));
    chk("R2", "smemWrN", smemWrN, !(mem && cycWrite && low));
    chk("R3", "rtcIdxWrN", rtcIdxWrN, !(io && cycWrite && p70));
    chk("R4", "rtcDatWrN", rtcDatWrN, !(io && cycWrite && p71));
    chk("R4", "rtcDatRdN", rtcDatRdN, !(io && !cycWrite && p71));
    chk("R5", "romRtcSelN", romRtcSelN, !((mem && rom) || (io && (p70 || p71))));
    chk("R6", "ioRdN", ioRdN, !(io && !cycWrite && !extMaster));
    chk("R6", "ioWrN", ioWrN, !(io && cycWrite && !extMaster));
    chk("R6", "ioCmdOe", ioCmdOe, !extMaster);
    chk("R7", "wide16", wide16, mem && !memSel16N);
    chk("R8", "ioSel16Oe", ioSel16Oe, 1'b0);
  endtask

  // Apply at a falling edge, compare at the next falling edge
  task automatic cyc(input bit v, input int t, input bit w, input logic [23:0] a,
                     input bit m, input bit s16);
    cycValid = v; cycType = 2'(t); cycWrite = w; cycAddr = a;
    extMaster = m; memSel16N = s16;
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cycValid = 1'b1; cycType = 2'd0; cycAddr = 24'h000000;  // busy inputs in reset
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9", "smemRdN", smemRdN, 1'b1);
    chk("R9", "romRtcSelN", romRtcSelN, 1'b1);
    chk("R9", "ioCmdOe", ioCmdOe, 1'b0);
    chk("R9", "wide16", wide16, 1'b0);
    rstN = 1'b1;
    cyc(0, 3, 0, 24'h0, 0, 1);
    // R1/R2 around 1 MB
    cyc(1, 0, 0, 24'h0FFFFF, 0, 1);
    cyc(1, 0, 0, 24'h100000, 0, 1);
    cyc(1, 0, 1, 24'h0FFFFF, 0, 1);
    cyc(1, 0, 1, 24'h100000, 0, 1);
    // refresh, read and write direction
    cyc(1, 2, 0, 24'h300000, 0, 1);
    cyc(1, 2, 1, 24'h300000, 0, 0);
    // R5 ROM windows
    cyc(1, 0, 0, 24'h0DFFFF, 0, 1);
    cyc(1, 0, 0, 24'h0E0000, 0, 0);
    cyc(1, 0, 1, 24'hFDFFFF, 0, 0);
    cyc(1, 0, 0, 24'hFE0000, 0, 1);
    // R3/R4 port decode
    cyc(1, 1, 1, 24'h000070, 0, 0);
    cyc(1, 1, 0, 24'h000070, 0, 1);
    cyc(1, 1, 1, 24'h000071, 0, 1);
    cyc(1, 1, 0, 24'h000071, 0, 0);
    cyc(1, 1, 1, 24'h000072, 0, 1);
    cyc(1, 1, 1, 24'h001070, 0, 1);
    // R6/R8 external master
    cyc(1, 1, 0, 24'h000071, 1, 1);
    cyc(1, 1, 1, 24'h000070, 1, 0);
    cyc(1, 1, 1, 24'h000300, 0, 1);
    // invalid descriptor
    cyc(0, 0, 0, 24'h000000, 0, 0);
    // R7 with mem select on memory cycles
    cyc(1, 0, 0, 24'h400000, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] a;
      int r;
      r = $urandom_range(0, 3);
      case (r)
        0: a = 24'(32'h00006E + $urandom_range(0, 5));
        1: a = 24'(32'h0E0000 - 2 + $urandom_range(0, 3));
        2: a = 24'(32'hFE0000 - 2 + $urandom_range(0, 3));
        default: a = 24'($urandom);
      endcase
      cyc(1'($urandom_range(0, 7) != 0), $urandom_range(0, 3), 1'($urandom),
          a, 1'($urandom_range(0, 3) == 0), 1'($urandom));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule